// File: doc/BRIEF.md
# Speculative Cache Coherence Controller

This block keeps the coherence state of every line of a small write-back first-level data cache that runs speculative threads. Each thread belongs to a logical epoch. Besides the usual Invalid, Exclusive, Shared and Dirty states, a line may sit in one of two speculative states. A line in a speculative state carries a speculatively-loaded mark (SL), a speculatively-modified mark (SM), or both.

The controller takes four kinds of input:
- local loads and stores, each flagged speculative or not;
- fill responses for outstanding misses;
- incoming coherence messages, which carry a flag telling whether the sender is logically earlier;
- epoch commit and squash strobes.

It emits one outgoing coherence message per cycle at most. It raises a violation pulse when an earlier epoch invalidates data that this epoch has already read speculatively. The interconnect, the data arrays and replacement live outside this block. A look-up port reads back the state of one line, as a tag lookup would.

Top module: `spec_coh_ctrl`

## Requirements

- R1: After reset every line reads Invalid with SL and SM clear, and `out_vld` and `violation` are low. State codes on `look_state`: Invalid 0, Exclusive 1, Shared 2, Dirty 3, speculative-exclusive 4, speculative-shared 5. A non-speculative state never shows SL or SM.
- R2: Non-speculative accesses:
  - A load miss sends Read. A fill marked shared then gives Shared, and a fill marked exclusive gives Exclusive.
  - A store miss sends Read-exclusive, and its fill gives Dirty.
  - A store to an Exclusive line turns it Dirty with no message.
  - A store to a Shared line sends Upgrade and turns it Dirty.
- R3: Speculative loads:
  - A hit on Exclusive or Shared moves the line to speculative-exclusive or speculative-shared and sets SL, with no message.
  - A miss sends Read. Its fill sets SL and picks the speculative state from the fill's shared or exclusive mark.
  - Every speculative state holds SL or SM.
- R4: Speculative stores:
  - A miss sends Read-exclusive-speculative. An exclusive fill gives speculative-exclusive and a shared fill gives speculative-shared, with SM set.
  - A store to a Shared line, or to a speculative-shared line that does not yet have SM, sends Upgrade-speculative and sets SM.
- R5: A speculative load or store to a Dirty line first sends Flush, so the committed copy reaches memory. The line then becomes speculative-exclusive with the new mark set.
- R6: An incoming Read, or a Read-exclusive-speculative from a later epoch, demotes a line that holds exclusive rights:
  - Dirty sends Flush and becomes Shared.
  - Exclusive sends Notify-shared and becomes Shared.
  - Speculative-exclusive sends Notify-shared and becomes speculative-shared.
- R7: An incoming Read-exclusive, Upgrade or Invalidation removes a non-speculative line. A Dirty line sends Writeback first; Exclusive and Shared lines go to Invalid silently.
- R8: The speculative variants Read-exclusive-speculative, Upgrade-speculative and Invalidation-speculative act by epoch. From an earlier epoch they behave as in R7. From a later epoch they leave the line, its marks and `violation` unchanged, apart from the sharing of R6.
- R9: An invalidating message from an earlier epoch has this effect on a speculative line:
  - If SL is set, `violation` pulses for one cycle and the line becomes Invalid with its marks cleared.
  - If only SM is set, the line stays as it is.
- R10: On commit, a speculative line is handled by its marks, and all marks clear:
  - with SM set, it becomes Dirty;
  - otherwise speculative-exclusive becomes Exclusive and speculative-shared becomes Shared.
- R11: On squash, all marks clear and any outstanding speculative miss is cancelled. Lines with SM set become Invalid. Other speculative lines return to Exclusive or Shared.
- R12: These rules decide which events in a cycle take effect:
  - Commit or squash in a cycle drops the local request, the fill and the incoming message of that cycle.
  - An incoming message drops a local request in the same cycle.
  - A fill to the line of a same-cycle local request drops that request.
  - A fill to a line with no outstanding miss is ignored.
- R13: `out_vld`, `out_msg`, `out_idx` and `violation` are registered and reflect the event sampled at the previous clock edge. Message codes on `out_msg` and `snp_msg`:

  | Code | Message |
  |------|---------|
  | 1 | Read |
  | 2 | Read-exclusive |
  | 3 | Upgrade |
  | 4 | Invalidation |
  | 5 | Writeback |
  | 6 | Flush |
  | 7 | Notify-shared |
  | 8 | Read-exclusive-speculative |
  | 9 | Upgrade-speculative |
  | 10 | Invalidation-speculative |

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Local access present |
| req_idx | input | IW | Line of the local access |
| req_store | input | 1 | 1 store, 0 load |
| req_spec | input | 1 | Access belongs to a speculative epoch |
| fil_vld | input | 1 | Fill response present |
| fil_idx | input | IW | Line of the fill |
| fil_excl | input | 1 | Fill grants exclusive access (0: shared) |
| snp_vld | input | 1 | Incoming coherence message present |
| snp_idx | input | IW | Line the message targets |
| snp_msg | input | 4 | Message code (R13) |
| snp_early | input | 1 | Sender is logically earlier |
| epoch_commit | input | 1 | Commit the current epoch |
| epoch_squash | input | 1 | Squash the current epoch |
| out_vld | output | 1 | Outgoing message valid |
| out_msg | output | 4 | Outgoing message code (R13) |
| out_idx | output | IW | Line of the outgoing message |
| violation | output | 1 | Dependence violation pulse |
| look_idx | input | IW | Line to read back |
| look_state | output | 3 | State of that line (R1 codes) |
| look_sl | output | 1 | Its SL mark |
| look_sm | output | 1 | Its SM mark |

## Verification

The bench builds the block with its default of four lines, so IW is 2. With four lines, one epoch can leave one line in each of several states: speculative-shared with SL only, with SM only, and with both, plus speculative-exclusive with both. A single commit or squash can then be checked against all of those states at once. Four lines also allow a same-cycle collision between a local request and a message aimed at a different line. That shows the drop rule depends on the cycle, not on the address.

// File: rtl/coh_pkg.sv
// Shared types for the speculative coherence controller.
// Assumes: state and message codes are visible at the ports and fixed.
package coh_pkg;

    typedef enum logic [2:0] {
        LS_INV = 3'd0,
        LS_EXC = 3'd1,
        LS_SHR = 3'd2,
        LS_DIR = 3'd3,
        LS_SPE = 3'd4,
        LS_SPS = 3'd5
    } line_st_t;

    typedef enum logic [3:0] {
        CM_NONE    = 4'd0,
        CM_READ    = 4'd1,
        CM_RDEX    = 4'd2,
        CM_UPGR    = 4'd3,
        CM_INV     = 4'd4,
        CM_WBACK   = 4'd5,
        CM_FLUSH   = 4'd6,
        CM_NSHR    = 4'd7,
        CM_RDEX_SP = 4'd8,
        CM_UPGR_SP = 4'd9,
        CM_INV_SP  = 4'd10
    } coh_msg_t;

    // True for the two speculative states.
    function automatic logic is_spec(line_st_t s);
        return (s == LS_SPE) || (s == LS_SPS);
    endfunction

endpackage

// File: rtl/coh_route.sv
// Event router: decides which events take effect this cycle and turns
// them into per-line strobes.
// Assumes: at most one local request, one fill and one incoming message
// per cycle; commit and squash act on every line.
module coh_route #(
    parameter int NUM_LINES = 4,
    parameter int IW        = 2
) (
    input  logic                 req_vld,
    input  logic [IW-1:0]        req_idx,
    input  logic                 fil_vld,
    input  logic [IW-1:0]        fil_idx,
    input  logic                 snp_vld,
    input  logic [IW-1:0]        snp_idx,
    input  logic                 commit,
    input  logic                 squash,
    output logic [NUM_LINES-1:0] loc_sel,
    output logic [NUM_LINES-1:0] fil_sel,
    output logic [NUM_LINES-1:0] snp_sel,
    output logic                 acc_snp
);
    import coh_pkg::*;

    logic glob;
    logic acc_fil;
    logic acc_loc;

    // Acceptance: global events win, then the incoming message, then a fill on the same line.
    always_comb begin
        glob    = commit | squash;
        acc_snp = snp_vld & ~glob;
        acc_fil = fil_vld & ~glob;
        acc_loc = req_vld & ~glob & ~snp_vld & ~(fil_vld && (fil_idx == req_idx));
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_dec
        localparam logic [IW-1:0] GI = IW'(g);
        // Address decode of each accepted event for line g.
        always_comb begin
            loc_sel[g] = acc_loc && (req_idx == GI);
            fil_sel[g] = acc_fil && (fil_idx == GI);
            snp_sel[g] = acc_snp && (snp_idx == GI);
        end
    end
endmodule

// File: rtl/coh_line.sv
// State machine of one cache line: coherence state, SL/SM marks and one
// outstanding miss. Produces this cycle's message and violation for
// the line.
// Assumes: the router never strobes loc_hit together with snp_hit, nor
// loc_hit together with fil_hit; squash outranks commit.
module coh_line (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               loc_hit,
    input  logic               loc_store,
    input  logic               loc_spec,
    input  logic               fil_hit,
    input  logic               fil_excl,
    input  logic               snp_hit,
    input  coh_pkg::coh_msg_t  snp_msg,
    input  logic               snp_early,
    input  logic               commit,
    input  logic               squash,
    output coh_pkg::line_st_t  st,
    output logic               sl,
    output logic               sm,
    output coh_pkg::coh_msg_t  msg,
    output logic               viol
);
    import coh_pkg::*;

    line_st_t n_st;
    logic     n_sl, n_sm;
    logic     pnd, pst, psp;         // miss outstanding, it is a store, it is speculative
    logic     n_pnd, n_pst, n_psp;
    logic     kill, share, spec_eff;

    // Next-state logic: global events, then message, then fill, then local access.
    always_comb begin
        n_st = st;   n_sl = sl;   n_sm = sm;
        n_pnd = pnd; n_pst = pst; n_psp = psp;
        msg  = CM_NONE;
        viol = 1'b0;
        kill = (snp_msg == CM_RDEX) || (snp_msg == CM_UPGR) || (snp_msg == CM_INV) ||
               (snp_early && ((snp_msg == CM_RDEX_SP) || (snp_msg == CM_UPGR_SP) ||
                              (snp_msg == CM_INV_SP)));
        share = (snp_msg == CM_READ) || (!snp_early && (snp_msg == CM_RDEX_SP));
        spec_eff = 1'b0;
        if (squash) begin
            if (is_spec(st)) n_st = sm ? LS_INV : ((st == LS_SPE) ? LS_EXC : LS_SHR);
            n_sl = 1'b0;
            n_sm = 1'b0;
            if (psp) n_pnd = 1'b0;
            n_psp = 1'b0;
        end else if (commit) begin
            if (is_spec(st)) n_st = sm ? LS_DIR : ((st == LS_SPE) ? LS_EXC : LS_SHR);
            n_sl  = 1'b0;
            n_sm  = 1'b0;
            n_psp = 1'b0;
        end else begin
            if (snp_hit) begin
                if (kill) begin
                    case (st)
                        LS_DIR: begin msg = CM_WBACK; n_st = LS_INV; end
                        LS_EXC, LS_SHR: n_st = LS_INV;
                        LS_SPE, LS_SPS: if (sl) begin
                            viol = 1'b1;
                            n_st = LS_INV;
                            n_sl = 1'b0;
                            n_sm = 1'b0;
                        end
                        default: ;
                    endcase
                end else if (share) begin
                    case (st)
                        LS_DIR: begin msg = CM_FLUSH; n_st = LS_SHR; end
                        LS_EXC: begin msg = CM_NSHR;  n_st = LS_SHR; end
                        LS_SPE: begin msg = CM_NSHR;  n_st = LS_SPS; end
                        default: ;
                    endcase
                end
            end
            if (fil_hit && n_pnd) begin
                n_pnd = 1'b0;
                if (n_psp) begin
                    n_st = fil_excl ? LS_SPE : LS_SPS;
                    if (n_pst) n_sm = 1'b1;
                    else       n_sl = 1'b1;
                end else if (n_pst) begin
                    n_st = LS_DIR;
                end else begin
                    n_st = fil_excl ? LS_EXC : LS_SHR;
                end
            end
            if (loc_hit) begin
                spec_eff = loc_spec || is_spec(n_st);
                if (n_st == LS_INV) begin
                    if (!n_pnd) begin
                        n_pnd = 1'b1;
                        n_pst = loc_store;
                        n_psp = spec_eff;
                        msg   = !loc_store ? CM_READ : (spec_eff ? CM_RDEX_SP : CM_RDEX);
                    end
                end else if (!spec_eff) begin
                    if (loc_store) begin
                        if (n_st == LS_SHR) msg = CM_UPGR;
                        n_st = LS_DIR;
                    end
                end else begin
                    case (n_st)
                        LS_EXC: n_st = LS_SPE;
                        LS_DIR: begin msg = CM_FLUSH; n_st = LS_SPE; end
                        LS_SHR: begin
                            n_st = LS_SPS;
                            if (loc_store) msg = CM_UPGR_SP;
                        end
                        LS_SPS: if (loc_store && !n_sm) msg = CM_UPGR_SP;
                        default: ;
                    endcase
                    if (loc_store) n_sm = 1'b1;
                    else           n_sl = 1'b1;
                end
            end
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= LS_INV; sl <= 1'b0; sm <= 1'b0;
            pnd <= 1'b0; pst <= 1'b0; psp <= 1'b0;
        end else begin
            st <= n_st; sl <= n_sl; sm <= n_sm;
            pnd <= n_pnd; pst <= n_pst; psp <= n_psp;
        end
    end
endmodule

// File: rtl/coh_emit.sv
// Output stage: picks the message of the line that the accepted event
// targets and registers message, line index and violation.
// Assumes: the router never selects a local request and an incoming
// message in the same cycle.
module coh_emit #(
    parameter int NUM_LINES = 4,
    parameter int IW        = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] loc_sel,
    input  logic [NUM_LINES-1:0] snp_sel,
    input  logic                 acc_snp,
    input  logic [IW-1:0]        snp_idx,
    input  logic [IW-1:0]        req_idx,
    input  coh_pkg::coh_msg_t    line_msg  [NUM_LINES],
    input  logic [NUM_LINES-1:0] line_viol,
    output logic                 out_vld,
    output logic [3:0]           out_msg,
    output logic [IW-1:0]        out_idx,
    output logic                 violation
);
    import coh_pkg::*;

    coh_msg_t msg_sel;
    logic     viol_sel;

    // Select the targeted line's message and violation.
    always_comb begin
        msg_sel  = CM_NONE;
        viol_sel = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (snp_sel[i] || loc_sel[i]) msg_sel = line_msg[i];
            viol_sel = viol_sel | (snp_sel[i] & line_viol[i]);
        end
    end

    // Register the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld   <= 1'b0;
            out_msg   <= 4'd0;
            out_idx   <= '0;
            violation <= 1'b0;
        end else begin
            out_vld   <= (msg_sel != CM_NONE);
            out_msg   <= msg_sel;
            out_idx   <= acc_snp ? snp_idx : req_idx;
            violation <= viol_sel;
        end
    end
endmodule

// File: rtl/spec_coh_ctrl.sv
// Top of the speculative coherence controller: router, one state machine
// per line, registered output stage and a read-back port for one line.
// Assumes: NUM_LINES is at least 1; indices beyond NUM_LINES select no line.
module spec_coh_ctrl #(
    parameter int NUM_LINES = 4,
    localparam int IW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_vld,
    input  logic [IW-1:0] req_idx,
    input  logic          req_store,
    input  logic          req_spec,
    input  logic          fil_vld,
    input  logic [IW-1:0] fil_idx,
    input  logic          fil_excl,
    input  logic          snp_vld,
    input  logic [IW-1:0] snp_idx,
    input  logic [3:0]    snp_msg,
    input  logic          snp_early,
    input  logic          epoch_commit,
    input  logic          epoch_squash,
    output logic          out_vld,
    output logic [3:0]    out_msg,
    output logic [IW-1:0] out_idx,
    output logic          violation,
    input  logic [IW-1:0] look_idx,
    output logic [2:0]    look_state,
    output logic          look_sl,
    output logic          look_sm
);
    import coh_pkg::*;

    logic [NUM_LINES-1:0] loc_sel, fil_sel, snp_sel;
    logic                 acc_snp;
    line_st_t             line_st   [NUM_LINES];
    coh_msg_t             line_msg  [NUM_LINES];
    logic [NUM_LINES-1:0] line_sl, line_sm, line_viol;

    coh_route #(.NUM_LINES(NUM_LINES), .IW(IW)) u_route (
        .req_vld(req_vld), .req_idx(req_idx), .fil_vld(fil_vld), .fil_idx(fil_idx),
        .snp_vld(snp_vld), .snp_idx(snp_idx), .commit(epoch_commit),
        .squash(epoch_squash), .loc_sel(loc_sel), .fil_sel(fil_sel),
        .snp_sel(snp_sel), .acc_snp(acc_snp)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        coh_line u_line (
            .clk(clk), .rst_n(rst_n),
            .loc_hit(loc_sel[g]), .loc_store(req_store), .loc_spec(req_spec),
            .fil_hit(fil_sel[g]), .fil_excl(fil_excl),
            .snp_hit(snp_sel[g]), .snp_msg(coh_msg_t'(snp_msg)), .snp_early(snp_early),
            .commit(epoch_commit), .squash(epoch_squash),
            .st(line_st[g]), .sl(line_sl[g]), .sm(line_sm[g]),
            .msg(line_msg[g]), .viol(line_viol[g])
        );
    end

    coh_emit #(.NUM_LINES(NUM_LINES), .IW(IW)) u_emit (
        .clk(clk), .rst_n(rst_n), .loc_sel(loc_sel), .snp_sel(snp_sel),
        .acc_snp(acc_snp), .snp_idx(snp_idx), .req_idx(req_idx),
        .line_msg(line_msg), .line_viol(line_viol),
        .out_vld(out_vld), .out_msg(out_msg), .out_idx(out_idx), .violation(violation)
    );

    // Read-back multiplexer for one line.
    always_comb begin
        look_state = 3'd0;
        look_sl    = 1'b0;
        look_sm    = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (look_idx == IW'(i)) begin
                look_state = line_st[i];
                look_sl    = line_sl[i];
                look_sm    = line_sm[i];
            end
        end
    end
endmodule

// File: rtl/coh_ctrl_chk.sv
// Property checker for spec_coh_ctrl, attached by bind.
// Assumes: state codes as in coh_pkg (4 and 5 are the speculative states).
module coh_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_vld,
    input logic       snp_vld,
    input logic       epoch_commit,
    input logic       epoch_squash,
    input logic       out_vld,
    input logic [3:0] out_msg,
    input logic       violation,
    input logic [2:0] look_state,
    input logic       look_sl,
    input logic       look_sm
);
    logic spec_st;

    // Flags a speculative state on the read-back port.
    always_comb spec_st = (look_state == 3'd4) || (look_state == 3'd5);

    a_r1_plain_no_marks: assert property (@(posedge clk) disable iff (!rst_n)
        !spec_st |-> (!look_sl && !look_sm));

    a_r3_spec_has_mark: assert property (@(posedge clk) disable iff (!rst_n)
        spec_st |-> (look_sl || look_sm));

    a_r9_viol_after_msg: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> $past(snp_vld));

    a_r10_commit_ends_spec: assert property (@(posedge clk) disable iff (!rst_n)
        epoch_commit |=> !spec_st);

    a_r11_squash_clears_sl: assert property (@(posedge clk) disable iff (!rst_n)
        epoch_squash |=> !look_sl);

    a_r12_global_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (epoch_commit || epoch_squash) |=> (!out_vld && !violation));

    a_r13_msg_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ($past(req_vld || snp_vld) && (out_msg != 4'd0)));
endmodule

bind spec_coh_ctrl coh_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .snp_vld(snp_vld),
    .epoch_commit(epoch_commit), .epoch_squash(epoch_squash),
    .out_vld(out_vld), .out_msg(out_msg), .violation(violation),
    .look_state(look_state), .look_sl(look_sl), .look_sm(look_sm)
);

// File: tb/sim_spec_coh_ctrl.sv
`timescale 1ns/1ps
module sim_spec_coh_ctrl;
    localparam int N  = 4;
    localparam int IW = 2;
    // state codes
    localparam int I = 0, E = 1, S = 2, D = 3, SE = 4, SS = 5;
    // message codes
    localparam int RD = 1, RDX = 2, UPG = 3, INV = 4, WB = 5, FL = 6, NS = 7,
                   RDXS = 8, UPGS = 9, INVS = 10;

    logic clk = 0, rst_n = 0;
    logic req_vld = 0, req_store = 0, req_spec = 0;
    logic [IW-1:0] req_idx = 0, fil_idx = 0, snp_idx = 0, look_idx = 0;
    logic fil_vld = 0, fil_excl = 0, snp_vld = 0, snp_early = 0;
    logic [3:0] snp_msg = 0;
    logic epoch_commit = 0, epoch_squash = 0;
    logic out_vld, violation, look_sl, look_sm;
    logic [3:0] out_msg;
    logic [IW-1:0] out_idx;
    logic [2:0] look_state;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    spec_coh_ctrl #(.NUM_LINES(N)) u0 (.*);

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk); @(negedge clk);
        req_vld = 0; fil_vld = 0; snp_vld = 0; epoch_commit = 0; epoch_squash = 0;
    endtask

    task automatic loc(int idx, bit store, bit spec);
        req_vld = 1; req_idx = IW'(idx); req_store = store; req_spec = spec; tick();
    endtask
    task automatic fil(int idx, bit excl);
        fil_vld = 1; fil_idx = IW'(idx); fil_excl = excl; tick();
    endtask
    task automatic snp(int idx, int m, bit early);
        snp_vld = 1; snp_idx = IW'(idx); snp_msg = 4'(m); snp_early = early; tick();
    endtask

    task automatic out_is(string tag, bit v, int m, int idx);
        chk({tag, " out_vld"}, out_vld, v);
        if (v) begin
            chk({tag, " out_msg"}, out_msg, m);
            chk({tag, " out_idx"}, out_idx, idx);
        end
    endtask
    task automatic line_is(string tag, int idx, int st, bit s_l, bit s_m);
        look_idx = IW'(idx); #1;
        chk({tag, " state"}, look_state, st);
        chk({tag, " sl"}, look_sl, s_l);
        chk({tag, " sm"}, look_sm, s_m);
    endtask

    task automatic t_reset;  // R1
        for (int i = 0; i < N; i++) line_is("R1 reset line", i, I, 0, 0);
        chk("R1 out_vld", out_vld, 0);
        chk("R1 violation", violation, 0);
    endtask

    task automatic t_plain;  // R2, R13
        loc(0, 0, 0); out_is("R2 load miss", 1, RD, 0); line_is("R2 pending", 0, I, 0, 0);
        fil(0, 0); out_is("R13 out clears", 0, 0, 0); line_is("R2 shared fill", 0, S, 0, 0);
        loc(1, 0, 0); out_is("R2 load miss1", 1, RD, 1);
        fil(1, 1); line_is("R2 excl fill", 1, E, 0, 0);
        loc(1, 1, 0); out_is("R2 store on E", 0, 0, 0); line_is("R2 E->D", 1, D, 0, 0);
        loc(0, 1, 0); out_is("R2 store on S", 1, UPG, 0); line_is("R2 S->D", 0, D, 0, 0);
        loc(2, 1, 0); out_is("R2 store miss", 1, RDX, 2);
        fil(2, 0); line_is("R2 rdex fill", 2, D, 0, 0);
    endtask

    task automatic t_snoop;  // R6, R7
        snp(0, RD, 0); out_is("R6 read on D", 1, FL, 0); line_is("R6 D->S", 0, S, 0, 0);
        snp(0, INV, 0); out_is("R7 inv on S", 0, 0, 0); line_is("R7 S->I", 0, I, 0, 0);
        snp(1, RDX, 0); out_is("R7 rdex on D", 1, WB, 1); line_is("R7 D->I", 1, I, 0, 0);
        loc(3, 0, 0); fil(3, 1);
        snp(3, RD, 0); out_is("R6 read on E", 1, NS, 3); line_is("R6 E->S", 3, S, 0, 0);
        snp(3, UPG, 0); out_is("R7 upg on S", 0, 0, 0); line_is("R7 upg S->I", 3, I, 0, 0);
    endtask

    task automatic t_spec;  // R3, R4, R5, R6, R8, R10
        loc(2, 0, 1); out_is("R5 spec load on D", 1, FL, 2); line_is("R5 D->SE", 2, SE, 1, 0);
        loc(2, 1, 1); out_is("R4 spec store on SE", 0, 0, 0); line_is("R4 SE sm", 2, SE, 1, 1);
        loc(3, 1, 1); out_is("R4 spec store miss", 1, RDXS, 3);
        fil(3, 0); line_is("R4 shared fill", 3, SS, 0, 1);
        loc(0, 0, 0); fil(0, 1);
        loc(0, 0, 1); out_is("R3 spec load on E", 0, 0, 0); line_is("R3 E->SE", 0, SE, 1, 0);
        loc(1, 0, 1); out_is("R3 spec load miss", 1, RD, 1);
        fil(1, 0); line_is("R3 shared fill", 1, SS, 1, 0);
        loc(1, 1, 1); out_is("R4 spec store on SS", 1, UPGS, 1); line_is("R4 SS sm", 1, SS, 1, 1);
        snp(0, RD, 0); out_is("R6 read on SE", 1, NS, 0); line_is("R6 SE->SS", 0, SS, 1, 0);
        snp(0, INVS, 0); chk("R8 later inv viol", violation, 0);
        out_is("R8 later inv", 0, 0, 0); line_is("R8 later inv kept", 0, SS, 1, 0);
        snp(3, UPGS, 0); line_is("R8 later upg kept", 3, SS, 0, 1);
        epoch_commit = 1; tick();
        line_is("R10 SS sl -> S", 0, S, 0, 0);
        line_is("R10 SS sl sm -> D", 1, D, 0, 0);
        line_is("R10 SE sl sm -> D", 2, D, 0, 0);
        line_is("R10 SS sm -> D", 3, D, 0, 0);
    endtask

    task automatic t_viol;  // R9, R5
        loc(0, 0, 1); line_is("R3 spec load on S", 0, SS, 1, 0);
        loc(1, 1, 1); out_is("R5 spec store on D", 1, FL, 1); line_is("R5 D->SE sm", 1, SE, 0, 1);
        snp(0, INVS, 1); chk("R9 violation", violation, 1);
        out_is("R9 no msg", 0, 0, 0); line_is("R9 SL line dropped", 0, I, 0, 0);
        snp(1, INVS, 1); chk("R9 sm only no violation", violation, 0);
        line_is("R9 sm only kept", 1, SE, 0, 1);
    endtask

    task automatic t_squash;  // R11, R8
        loc(3, 0, 1); out_is("R5 spec load on D3", 1, FL, 3);
        loc(2, 1, 1); out_is("R5 spec store on D2", 1, FL, 2);
        epoch_squash = 1; tick();
        line_is("R11 SE sm -> I", 1, I, 0, 0);
        line_is("R11 SE sm -> I (2)", 2, I, 0, 0);
        line_is("R11 SE sl -> E", 3, E, 0, 0);
        snp(3, RDXS, 1); out_is("R8 early rdex sp", 0, 0, 0); line_is("R8 early rdex sp E->I", 3, I, 0, 0);
        loc(2, 0, 1); out_is("R3 spec load miss2", 1, RD, 2);
        epoch_squash = 1; tick();
        fil(2, 1); line_is("R11 miss cancelled", 2, I, 0, 0);
    endtask

    task automatic t_prio;  // R12
        req_vld = 1; req_idx = 0; req_store = 0; req_spec = 0;
        snp_vld = 1; snp_idx = 3; snp_msg = RD; snp_early = 0; tick();
        out_is("R12 local dropped by msg", 0, 0, 0);
        fil(0, 1); line_is("R12 no miss opened", 0, I, 0, 0);
        req_vld = 1; req_idx = 1; req_store = 0; req_spec = 0; epoch_commit = 1; tick();
        out_is("R12 local dropped by commit", 0, 0, 0);
        fil(1, 1); line_is("R12 no miss opened 1", 1, I, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_snoop();
        t_spec();
        t_viol();
        t_squash();
        t_prio();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule